// File: doc/BRIEF.md
# Asynchronous Bus Write-Cycle Controller

This block is the master side of a write transfer on an asynchronous external bus. The bus carries a 24-bit address, a 3-bit function code, a 2-bit size code and 16-bit data. A one-cycle request from the core is accepted only while the controller is idle. The address, function code, size and write data are captured at that point. The controller then runs a fixed sequence of bus states: address setup, address strobe, data drive, data strobe with wait, and termination.

Termination comes from one of two sources. The first is an active-low acknowledge returned by the addressed peripheral. The second is an active-high fast-termination acknowledge raised by an on-chip chip-select unit. The controller samples the acknowledge on the falling clock edge while the data strobe is out. When the acknowledge is present, it releases both strobes on the next rising edge and keeps the data bus driven for that one closing state. A one-cycle done pulse follows, and a new request may be accepted in that same cycle.

The data bus is exposed as a value plus an output enable, so that the pad ring or an upper level can build the tristate driver.

Top module: `abus_wr_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release with no request: `as_no`=1, `ds_no`=1, `rw_no`=1, `data_oe_o`=0, `busy_o`=0, `done_o`=0.
- R2: A request with `req_i`=1 sampled on a rising edge while idle starts the cycle. In the following clock (S0), `rw_no`=0 (0 means write), `addr_o`/`fc_o`/`siz_o` show the captured inputs, both strobes are 1 (negated), and `data_oe_o`=0.
- R3: `as_no` is 0 from the second clock of the cycle (S1) until the acknowledge is taken, and is 1 again in the closing state.
- R4: From the third clock (S2) through the closing state, `data_oe_o`=1 and `data_o` equals the captured write data. `data_oe_o` is 0 in the clock after the closing state.
- R5: `ds_no` is 0 from the fourth clock (S3), and the controller remains there for as long as no acknowledge is sampled.
- R6: An acknowledge of `dsack_ni`=0, sampled on a falling clock edge during S3, moves the controller directly to the closing state S5 on the next rising edge. In S5 both strobes are 1 and the data is still driven. The total is 5+D clocks from the accepting edge to the done clock, where D is the number of S3 clocks.
- R7: `done_o` is 1 for exactly one clock, the clock after S5. In that clock `busy_o`=0.
- R8: A request that arrives while `busy_o`=1 is ignored. The captured address and data do not change, no extra transfer follows, and the running cycle keeps its length.
- R9: `cs_ack_i`=1, sampled on a falling edge in S3, terminates the cycle in the same way as the external acknowledge.
- R10: A request sampled in the done clock starts the next cycle at once, with no idle clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the states change on the rising edge, the acknowledge is sampled on the falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Write request from the core |
| addr_i | input | 24 | Address to write |
| fc_i | input | 3 | Function code |
| siz_i | input | 2 | Operand size code |
| wdata_i | input | 16 | Write data |
| dsack_ni | input | 1 | Peripheral acknowledge, active low |
| cs_ack_i | input | 1 | Fast-termination acknowledge from the chip-select unit, active high |
| addr_o | output | 24 | Bus address |
| fc_o | output | 3 | Bus function code |
| siz_o | output | 2 | Bus size code |
| rw_no | output | 1 | Read/write line; 0 means write |
| as_no | output | 1 | Address strobe, active low |
| ds_no | output | 1 | Data strobe, active low |
| data_o | output | 16 | Data bus value |
| data_oe_o | output | 1 | Data bus output enable |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-clock pulse after the closing state |

## Verification
The write sequence is run with a peripheral that acknowledges after one, two and five strobe clocks. These runs separate an acknowledge taken on the first falling edge from a true wait in S3, and confirm that the latency grows by one clock per wait clock. The same cycle is also terminated by the chip-select acknowledge alone, which shows that either source is enough. A run flooded with spurious requests that carry different addresses shows that nothing is captured while busy. A chained pair of requests, the second issued in the done clock, separates a correct immediate restart from a controller that inserts an idle clock or drops the request.

// File: rtl/abus_wr_pkg.sv
package abus_wr_pkg;

  typedef enum logic [2:0] {
    ST_S0   = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_S4   = 3'd4,
    ST_S5   = 3'd5,
    ST_IDLE = 3'd6
  } wr_state_e;

  // address strobe is out from S1 up to the wait states
  function automatic logic as_on(input wr_state_e st);
    return (st == ST_S1) || (st == ST_S2) || (st == ST_S3) || (st == ST_S4);
  endfunction

  // data strobe covers the wait states only
  function automatic logic ds_on(input wr_state_e st);
    return (st == ST_S3) || (st == ST_S4);
  endfunction

  // data bus driven from S2 up to and including the closing state
  function automatic logic bus_drive(input wr_state_e st);
    return (st == ST_S2) || (st == ST_S3) || (st == ST_S4) || (st == ST_S5);
  endfunction

  function automatic logic in_cycle(input wr_state_e st);
    return st != ST_IDLE;
  endfunction

endpackage

// File: rtl/abus_wr_lat.sv
module abus_wr_lat #(
  parameter int AW = 24,
  parameter int FW = 3,
  parameter int SW = 2,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [FW-1:0] fc_i,
  input  logic [SW-1:0] siz_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] addr_q,
  output logic [FW-1:0] fc_q,
  output logic [SW-1:0] siz_q,
  output logic [DW-1:0] data_q
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      fc_q   <= '0;
      siz_q  <= '0;
      data_q <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      fc_q   <= fc_i;
      siz_q  <= siz_i;
      data_q <= data_i;
    end
  end

endmodule

// File: rtl/abus_wr_ack.sv
module abus_wr_ack (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic dsack_ni,
  input  logic cs_ack_i,
  output logic seen_q
);

  // falling-edge sample, half a clock ahead of the state register
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= arm_i && (!dsack_ni || cs_ack_i);
  end

endmodule

// File: rtl/abus_wr_seq.sv
module abus_wr_seq
  import abus_wr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  logic      ack_i,
  output wr_state_e state_q,
  output logic      start_o,
  output logic      done_q
);

  wr_state_e state_d;

  assign start_o = req_i && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_o) state_d = ST_S0;
      ST_S0:   state_d = ST_S1;
      ST_S1:   state_d = ST_S2;
      ST_S2:   state_d = ST_S3;
      ST_S3:   if (ack_i) state_d = ST_S5;
      ST_S4:   state_d = ST_S5;
      ST_S5:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_S5);
    end
  end

endmodule

// File: rtl/abus_wr_ctrl.sv
module abus_wr_ctrl
  import abus_wr_pkg::*;
#(
  parameter int AW = 24,
  parameter int FW = 3,
  parameter int SW = 2,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [FW-1:0] fc_i,
  input  logic [SW-1:0] siz_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          dsack_ni,
  input  logic          cs_ack_i,
  output logic [AW-1:0] addr_o,
  output logic [FW-1:0] fc_o,
  output logic [SW-1:0] siz_o,
  output logic          rw_no,
  output logic          as_no,
  output logic          ds_no,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          busy_o,
  output logic          done_o
);

  wr_state_e state_q;
  logic      start_w;
  logic      ack_w;
  logic      arm_w;

  assign arm_w = (state_q == ST_S3);

  abus_wr_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .ack_i   (ack_w),
    .state_q (state_q),
    .start_o (start_w),
    .done_q  (done_o)
  );

  abus_wr_ack u_ack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm_w),
    .dsack_ni (dsack_ni),
    .cs_ack_i (cs_ack_i),
    .seen_q   (ack_w)
  );

  abus_wr_lat #(.AW(AW), .FW(FW), .SW(SW), .DW(DW)) u_lat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_w),
    .addr_i (addr_i),
    .fc_i   (fc_i),
    .siz_i  (siz_i),
    .data_i (wdata_i),
    .addr_q (addr_o),
    .fc_q   (fc_o),
    .siz_q  (siz_o),
    .data_q (data_o)
  );

  assign busy_o    = in_cycle(state_q);
  assign rw_no     = !in_cycle(state_q);
  assign as_no     = !as_on(state_q);
  assign ds_no     = !ds_on(state_q);
  assign data_oe_o = bus_drive(state_q);

endmodule

// File: rtl/abus_wr_chk.sv
module abus_wr_chk
  import abus_wr_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input wr_state_e     state_q,
  input logic          as_no,
  input logic          ds_no,
  input logic          rw_no,
  input logic          data_oe_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [AW-1:0] addr_o,
  input logic [DW-1:0] data_o
);

  p_s0_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_S0) |-> (as_no && ds_no && !data_oe_o && !rw_no));

  p_ds_inside_as_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ds_no |-> !as_no);

  p_drive_is_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !rw_no);

  p_as_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(as_no) |-> (data_oe_o && ds_no));

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o || state_q == ST_S0));

  p_hold_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || ($stable(addr_o) && $stable(data_o))));

endmodule

bind abus_wr_ctrl abus_wr_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .state_q   (state_q),
  .as_no     (as_no),
  .ds_no     (ds_no),
  .rw_no     (rw_no),
  .data_oe_o (data_oe_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .addr_o    (addr_o),
  .data_o    (data_o)
);

// File: tb/abus_wr_ctrl_tb.sv
module abus_wr_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [23:0] addr_in = '0;
  logic [2:0]  fc_in = '0;
  logic [1:0]  siz_in = '0;
  logic [15:0] wd_in = '0;
  logic        dsack_n = 1'b1;
  logic        cs_ack = 1'b0;
  logic [23:0] addr_o;
  logic [2:0]  fc_o;
  logic [1:0]  siz_o;
  logic        rw_no, as_no, ds_no, data_oe, busy, done;
  logic [15:0] data_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  abus_wr_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr_in), .fc_i(fc_in),
    .siz_i(siz_in), .wdata_i(wd_in), .dsack_ni(dsack_n), .cs_ack_i(cs_ack),
    .addr_o(addr_o), .fc_o(fc_o), .siz_o(siz_o), .rw_no(rw_no), .as_no(as_no),
    .ds_no(ds_no), .data_o(data_o), .data_oe_o(data_oe), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // peripheral model: latches the bus while strobed, acknowledges after per_dly strobe clocks
  int          per_dly = 1;
  int          per_mode = 0;  // 0 external acknowledge, 1 chip-select acknowledge
  int          per_cnt = 0;
  logic [23:0] per_addr = '0;
  logic [15:0] per_data = '0;

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      dsack_n = 1'b1; cs_ack = 1'b0; per_cnt = 0;
    end else if (!ds_no) begin
      per_cnt++;
      per_addr = addr_o;
      per_data = data_o;
      if (per_cnt >= per_dly) begin
        if (per_mode == 0) dsack_n = 1'b0;
        else               cs_ack = 1'b1;
      end
    end else begin
      per_cnt = 0; dsack_n = 1'b1; cs_ack = 1'b0;
    end
  end

  // behavioural reference: phase number 0 idle, 1..4 = S0..S3, 6 = closing state
  int          m_phase = 0;
  bit          m_done = 0;
  bit          m_ack = 0;
  logic [44:0] m_cur = '0;       // {siz, fc, addr, ... } packed as addr,data below
  logic [23:0] e_addr = '0;
  logic [2:0]  e_fc = '0;
  logic [1:0]  e_siz = '0;
  logic [15:0] e_data = '0;
  logic [39:0] m_q[$];           // {addr, data} of every accepted write

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_done = 0; m_ack = 0;
    end else begin
      m_done = (m_phase == 6);
      case (m_phase)
        0: if (req) begin
             m_phase = 1;
             e_addr = addr_in; e_fc = fc_in; e_siz = siz_in; e_data = wd_in;
             m_q.push_back({addr_in, wd_in});
           end
        1, 2, 3: m_phase = m_phase + 1;
        4: if (m_ack) begin m_phase = 6; m_ack = 0; end
        default: m_phase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_phase == 4 && (!dsack_n || cs_ack)) m_ack = 1;
  end

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3", "as_n", as_no, !(m_phase >= 2 && m_phase <= 4));
      chk("R5", "ds_n", ds_no, !(m_phase == 4));
      chk("R4", "data_oe", data_oe, (m_phase >= 3 && m_phase <= 6));
      chk("R2", "rw_n", rw_no, (m_phase == 0));
      chk("R8", "busy", busy, (m_phase != 0));
      chk("R7", "done", done, m_done);
      if (m_phase != 0) begin
        chk("R2", "addr", addr_o, e_addr);
        chk("R2", "fc", fc_o, e_fc);
        chk("R2", "siz", siz_o, e_siz);
      end
      if (m_phase >= 3) chk("R4", "data", data_o, e_data);
    end
  end

  // one write; called at a falling edge; returns at the falling edge of the done clock
  task automatic do_write(input string tag, input logic [23:0] a, input logic [2:0] f,
                          input logic [1:0] s, input logic [15:0] d, input int dly,
                          input int mode, input bit noise);
    int n = 0;
    logic [39:0] exp_w;
    per_dly = dly; per_mode = mode;
    addr_in = a; fc_in = f; siz_in = s; wd_in = d; req = 1'b1;
    forever begin
      @(posedge clk); #1; req = 1'b0; n++;
      @(negedge clk);
      if (done) break;
      if (n > 200) break;
      if (noise) begin
        req = 1'b1; addr_in = a ^ 24'h5A5A5A ^ 24'(n); wd_in = ~d ^ 16'(n);
      end
    end
    chk(tag, "latency", n, 5 + dly);
    chk("R7", "busy_in_done", busy, 0);
    if (m_q.size() > 0) exp_w = m_q.pop_front(); else exp_w = '1;
    chk(tag, "periph_addr", per_addr, exp_w[39:16]);
    chk(tag, "periph_data", per_data, exp_w[15:0]);
    chk("R8", "no_extra_write", m_q.size(), 0);
  endtask

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "as_n_rst", as_no, 1);
    chk("R1", "ds_n_rst", ds_no, 1);
    chk("R1", "rw_n_rst", rw_no, 1);
    chk("R1", "oe_rst", data_oe, 0);
    chk("R1", "busy_rst", busy, 0);
    chk("R1", "done_rst", done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "idle_after_rst", {busy, as_no, ds_no, data_oe}, 4'b0110);

    do_write("R6", 24'h123456, 3'd5, 2'd1, 16'hBEEF, 1, 0, 0);
    repeat (2) @(negedge clk);
    do_write("R5", 24'hFFFFFF, 3'd1, 2'd2, 16'h0001, 2, 0, 0);
    repeat (2) @(negedge clk);
    do_write("R5", 24'h000000, 3'd7, 2'd0, 16'hFFFF, 5, 0, 0);
    repeat (2) @(negedge clk);
    do_write("R9", 24'hA0B0C0, 3'd2, 2'd3, 16'h1234, 1, 1, 0);
    repeat (2) @(negedge clk);
    do_write("R9", 24'h0F0F0F, 3'd6, 2'd1, 16'h8001, 3, 1, 0);
    repeat (2) @(negedge clk);
    do_write("R8", 24'h345678, 3'd3, 2'd2, 16'hC3C3, 3, 0, 1);
    chk("R8", "addr_kept", addr_o, 24'h345678);
    repeat (2) @(negedge clk);
    // back-to-back: second request is raised in the done clock
    do_write("R10", 24'h111111, 3'd1, 2'd1, 16'h1111, 1, 0, 0);
    do_write("R10", 24'h222222, 3'd2, 2'd2, 16'h2222, 2, 1, 0);
    repeat (3) @(negedge clk);
    chk("R7", "idle_end", {busy, done, data_oe}, 3'b000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule